// File: doc/BRIEF.md
# Round-Robin Wavefront Dispatcher

This block sits inside one compute unit and turns an accepted thread block into wavefronts of 64 threads. Each wavefront gets a sequential wave id and goes to one of several SIMD units. A SIMD unit holds at most one wavefront at a time, so only idle units can receive a wave. The unit that gets the next wave is chosen by a rotating pointer. At most one wave issues per cycle.

Each issue carries the wave id and the block index and block size it came from. It also carries the first thread index of the wave (wave_id × 64), the number of valid threads in the wave, and the number of 16-lane passes the SIMD unit needs to cover those threads. A thread's index inside its block is that base plus pass × 16 plus lane. A per-unit completion pulse makes the unit idle again. When every issued wave has completed, the block-done flag is raised for one cycle and the dispatcher accepts the next block.

Top module: `wave_dispatch`

## Requirements
- R1: After reset, `issue_valid` and `block_done` are low and `blk_ready` is high.
- R2: A block of size D produces ceil(D/64) issues, with wave ids 0, 1, 2, … in order and at most one issue per cycle.
- R3: `issue_thr_cnt` is 64 for every wave except the last, which carries D − 64·(waves − 1). It always lies between 1 and 64.
- R4: `issue_tid_base` equals `issue_wave_id` × 64.
- R5: `issue_passes` equals ceil(`issue_thr_cnt` / 16).
- R6: `issue_simd` is one-hot, with bit i meaning SIMD unit i. It never selects a unit that holds a wave.
- R7: After reset the rotation starts at unit 0. After unit g is granted, the search starts at unit g+1 (wrapping), and the first idle unit in that order is granted in the same cycle.
- R8: A unit becomes eligible again in the cycle after its `simd_done` bit is high. A `simd_done` bit for a unit that holds no wave has no effect.
- R9: `block_done` is a single-cycle pulse. It comes two cycles after the cycle in which the last outstanding completion arrives. A block of size 0 issues nothing and still produces the pulse.
- R10: `blk_ready` is low from block acceptance until the `block_done` pulse. A `blk_valid` during that time is ignored.
- R11: `issue_blk_idx` and `issue_blk_dim` repeat the accepted block's index and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | A block is offered |
| blk_ready | output | 1 | Dispatcher is free to take a block |
| blk_idx | input | BIDX_W | Index of the offered block |
| blk_dim | input | DIM_W | Thread count of the offered block |
| simd_done | input | NUM_SIMD | Per-unit completion pulse |
| issue_valid | output | 1 | A wave is issued this cycle |
| issue_simd | output | NUM_SIMD | One-hot target SIMD unit |
| issue_wave_id | output | WID_W | Wave id within the block |
| issue_blk_idx | output | BIDX_W | Block index of the wave |
| issue_blk_dim | output | DIM_W | Block size of the wave |
| issue_tid_base | output | DIM_W | First thread index of the wave |
| issue_thr_cnt | output | CNT_W | Valid threads in the wave |
| issue_passes | output | CYC_W | 16-lane passes needed per instruction |
| block_done | output | 1 | All waves of the block completed |

## Verification
The assertions check, on every cycle, the following:
- Each grant is one-hot and goes to a unit that was idle.
- The thread count stays in range.
- `block_done` never lasts two cycles.
- No issue happens while a new block could be accepted.

Only the bench scenarios show the rest:
- The rotation order when some units are busy, including the wrap past the last unit.
- The wave count and last-wave thread count for each block size.
- The arrival time of `block_done` and the case of an empty block.
- That an offer made during a running block is ignored.

// File: rtl/wd_pkg.sv
package wd_pkg;
   // ceiling division for elaboration-time sizing
   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
endpackage

// File: rtl/wd_rr_pick.sv
module wd_rr_pick #(
   parameter int N     = 4,
   parameter int SEL_W = 2
) (
   input  logic [N-1:0]     idle,
   input  logic [SEL_W-1:0] ptr,
   output logic             found,
   output logic [SEL_W-1:0] pick
);
   // lowest rotation distance from ptr wins
   always_comb begin
      int idx;
      found = 1'b0;
      pick  = ptr;
      for (int k = N - 1; k >= 0; k--) begin
         idx = int'(ptr) + k;
         if (idx >= N) idx = idx - N;
         if (idle[idx]) begin
            found = 1'b1;
            pick  = SEL_W'(idx);
         end
      end
   end
endmodule

// File: rtl/wd_wave_slicer.sv
module wd_wave_slicer #(
   parameter int WAVE_SIZE  = 64,
   parameter int SIMD_WIDTH = 16,
   parameter int DIM_W      = 10,
   parameter int WID_W      = 5,
   parameter int CNT_W      = 7,
   parameter int CYC_W      = 3
) (
   input  logic [DIM_W-1:0] dim,
   input  logic [WID_W-1:0] wave,
   output logic [DIM_W-1:0] tid_base,
   output logic [CNT_W-1:0] thr_cnt,
   output logic [CYC_W-1:0] passes
);
   localparam int LOG_WS = $clog2(WAVE_SIZE);
   localparam int LOG_SW = $clog2(SIMD_WIDTH);

   logic [DIM_W:0] base_ext;
   logic [DIM_W:0] remain;

   assign base_ext = {wave, {LOG_WS{1'b0}}};
   assign remain   = {1'b0, dim} - base_ext;
   assign tid_base = base_ext[DIM_W-1:0];
   assign thr_cnt  = (remain >= (DIM_W+1)'(WAVE_SIZE)) ? CNT_W'(WAVE_SIZE)
                                                       : remain[CNT_W-1:0];

   generate
      if (LOG_SW == LOG_WS) begin : g_single_pass
         assign passes = CYC_W'(thr_cnt != '0);
      end else begin : g_multi_pass
         logic [CNT_W:0] rounded;
         assign rounded = {1'b0, thr_cnt} + (CNT_W+1)'(SIMD_WIDTH - 1);
         assign passes  = CYC_W'(rounded >> LOG_SW);
      end
   endgenerate
endmodule

// File: rtl/wave_dispatch.sv
module wave_dispatch
   import wd_pkg::*;
#(
   parameter int NUM_SIMD   = 4,
   parameter int WAVE_SIZE  = 64,
   parameter int SIMD_WIDTH = 16,
   parameter int DIM_W      = 10,
   parameter int BIDX_W     = 8,
   localparam int LOG_WS = $clog2(WAVE_SIZE),
   localparam int WID_W  = DIM_W + 1 - LOG_WS,
   localparam int CNT_W  = $clog2(WAVE_SIZE + 1),
   localparam int CYC_W  = $clog2(ceil_div(WAVE_SIZE, SIMD_WIDTH) + 1),
   localparam int SEL_W  = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                blk_valid,
   output logic                blk_ready,
   input  logic [BIDX_W-1:0]   blk_idx,
   input  logic [DIM_W-1:0]    blk_dim,
   input  logic [NUM_SIMD-1:0] simd_done,
   output logic                issue_valid,
   output logic [NUM_SIMD-1:0] issue_simd,
   output logic [WID_W-1:0]    issue_wave_id,
   output logic [BIDX_W-1:0]   issue_blk_idx,
   output logic [DIM_W-1:0]    issue_blk_dim,
   output logic [DIM_W-1:0]    issue_tid_base,
   output logic [CNT_W-1:0]    issue_thr_cnt,
   output logic [CYC_W-1:0]    issue_passes,
   output logic                block_done
);
   // elaboration-time parameter checks
   generate
      if (NUM_SIMD < 2) begin : g_bad_simd
         $error("NUM_SIMD must be at least 2");
      end
      if ((1 << LOG_WS) != WAVE_SIZE) begin : g_bad_wave
         $error("WAVE_SIZE must be a power of two");
      end
      if ((1 << $clog2(SIMD_WIDTH)) != SIMD_WIDTH || SIMD_WIDTH > WAVE_SIZE) begin : g_bad_width
         $error("SIMD_WIDTH must be a power of two not above WAVE_SIZE");
      end
      if (DIM_W <= LOG_WS) begin : g_bad_dim
         $error("DIM_W must exceed log2(WAVE_SIZE)");
      end
   endgenerate

   logic                active_q;
   logic [DIM_W-1:0]    dim_q;
   logic [BIDX_W-1:0]   idx_q;
   logic [WID_W-1:0]    total_q, next_q;
   logic [NUM_SIMD-1:0] busy_q;
   logic [SEL_W-1:0]    ptr_q;

   logic                found;
   logic [SEL_W-1:0]    pick;
   logic                grant;
   logic                finish;
   logic [NUM_SIMD-1:0] grant_vec;
   logic [DIM_W:0]      dim_round;
   logic [DIM_W-1:0]    s_base;
   logic [CNT_W-1:0]    s_cnt;
   logic [CYC_W-1:0]    s_passes;
   logic [SEL_W-1:0]    ptr_after;

   wd_rr_pick #(.N(NUM_SIMD), .SEL_W(SEL_W)) u_pick (
      .idle  (~busy_q),
      .ptr   (ptr_q),
      .found (found),
      .pick  (pick)
   );

   wd_wave_slicer #(
      .WAVE_SIZE(WAVE_SIZE), .SIMD_WIDTH(SIMD_WIDTH), .DIM_W(DIM_W),
      .WID_W(WID_W), .CNT_W(CNT_W), .CYC_W(CYC_W)
   ) u_slice (
      .dim      (dim_q),
      .wave     (next_q),
      .tid_base (s_base),
      .thr_cnt  (s_cnt),
      .passes   (s_passes)
   );

   assign blk_ready = ~active_q;
   assign dim_round = {1'b0, blk_dim} + (DIM_W+1)'(WAVE_SIZE - 1);
   assign grant     = active_q && (next_q != total_q) && found;
   assign finish    = active_q && (next_q == total_q) && (busy_q == '0);
   assign grant_vec = grant ? (NUM_SIMD'(1) << pick) : '0;

   generate
      if ((1 << SEL_W) == NUM_SIMD) begin : g_wrap_pow2
         assign ptr_after = pick + SEL_W'(1);
      end else begin : g_wrap_cmp
         assign ptr_after = (pick == SEL_W'(NUM_SIMD - 1)) ? '0 : pick + SEL_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q       <= 1'b0;
         dim_q          <= '0;
         idx_q          <= '0;
         total_q        <= '0;
         next_q         <= '0;
         busy_q         <= '0;
         ptr_q          <= '0;
         issue_valid    <= 1'b0;
         issue_simd     <= '0;
         issue_wave_id  <= '0;
         issue_blk_idx  <= '0;
         issue_blk_dim  <= '0;
         issue_tid_base <= '0;
         issue_thr_cnt  <= '0;
         issue_passes   <= '0;
         block_done     <= 1'b0;
      end else begin
         busy_q      <= (busy_q & ~simd_done) | grant_vec;
         issue_valid <= grant;
         block_done  <= finish;
         if (blk_valid && !active_q) begin
            active_q <= 1'b1;
            dim_q    <= blk_dim;
            idx_q    <= blk_idx;
            total_q  <= dim_round[DIM_W:LOG_WS];
            next_q   <= '0;
         end else if (finish) begin
            active_q <= 1'b0;
         end
         if (grant) begin
            next_q         <= next_q + WID_W'(1);
            ptr_q          <= ptr_after;
            issue_simd     <= grant_vec;
            issue_wave_id  <= next_q;
            issue_blk_idx  <= idx_q;
            issue_blk_dim  <= dim_q;
            issue_tid_base <= s_base;
            issue_thr_cnt  <= s_cnt;
            issue_passes   <= s_passes;
         end
      end
   end
endmodule

// File: rtl/wave_dispatch_chk.sv
module wave_dispatch_chk #(
   parameter int NUM_SIMD  = 4,
   parameter int WAVE_SIZE = 64,
   parameter int CNT_W     = 7
) (
   input logic                clk,
   input logic                rst_n,
   input logic                issue_valid,
   input logic [NUM_SIMD-1:0] issue_simd,
   input logic [CNT_W-1:0]    issue_thr_cnt,
   input logic                block_done,
   input logic                blk_ready,
   input logic [NUM_SIMD-1:0] busy_q
);
   a_r6_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> $countones(issue_simd) == 1);

   a_r6_idle_target: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (issue_simd & $past(busy_q)) == '0);

   a_r3_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (issue_thr_cnt != '0 && issue_thr_cnt <= CNT_W'(WAVE_SIZE)));

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      block_done |=> !block_done);

   a_r10_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> !blk_ready);
endmodule

bind wave_dispatch wave_dispatch_chk #(
   .NUM_SIMD(NUM_SIMD), .WAVE_SIZE(WAVE_SIZE), .CNT_W(CNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .issue_valid   (issue_valid),
   .issue_simd    (issue_simd),
   .issue_thr_cnt (issue_thr_cnt),
   .block_done    (block_done),
   .blk_ready     (blk_ready),
   .busy_q        (busy_q)
);

// File: tb/wave_dispatch_test.sv
module wave_dispatch_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       blk_valid = 1'b0;
   logic       blk_ready;
   logic [7:0] blk_idx = '0;
   logic [9:0] blk_dim = '0;
   logic [3:0] simd_done = '0;
   logic       issue_valid;
   logic [3:0] issue_simd;
   logic [4:0] issue_wave_id;
   logic [7:0] issue_blk_idx;
   logic [9:0] issue_blk_dim;
   logic [9:0] issue_tid_base;
   logic [6:0] issue_thr_cnt;
   logic [2:0] issue_passes;
   logic       block_done;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  ended = 1'b0;

   always #2.5 clk = ~clk;

   wave_dispatch uut (.*);

   // size, expected wave count, expected last-wave thread count
   localparam int TBL[8][3] = '{
      '{1, 1, 1}, '{64, 1, 64}, '{65, 2, 1}, '{200, 4, 8},
      '{256, 4, 64}, '{0, 0, 0}, '{1023, 16, 63}, '{130, 3, 2}
   };

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic expect_issue(input int simd, input int wid);
      chk(issue_valid == 1'b1, "R7 issue present", issue_valid, 1);
      chk(issue_simd == 4'(1 << simd), "R7 rotation target", issue_simd, 1 << simd);
      chk(issue_wave_id == 5'(wid), "R2 wave id", issue_wave_id, wid);
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(issue_valid == 1'b0, "R1 issue_valid", issue_valid, 0);
      chk(block_done == 1'b0, "R1 block_done", block_done, 0);
      chk(blk_ready == 1'b1, "R1 blk_ready", blk_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: R7 rotation with busy units, R8 release, R10 ignored offer
      blk_valid = 1'b1; blk_dim = 10'd384; blk_idx = 8'd7;
      @(negedge clk); blk_valid = 1'b0;
      @(negedge clk); expect_issue(0, 0);
      @(negedge clk); expect_issue(1, 1);
      chk(blk_ready == 1'b0, "R10 ready low in block", blk_ready, 0);
      blk_valid = 1'b1; blk_dim = 10'd5; blk_idx = 8'd99;
      @(negedge clk); expect_issue(2, 2);
      blk_valid = 1'b0;
      @(negedge clk); expect_issue(3, 3);
      chk(issue_blk_idx == 8'd7, "R10 offer ignored idx", issue_blk_idx, 7);
      chk(issue_blk_dim == 10'd384, "R11 dim echo", issue_blk_dim, 384);
      @(negedge clk);
      chk(issue_valid == 1'b0, "R6 no idle unit", issue_valid, 0);
      simd_done = 4'b0100;
      @(negedge clk); simd_done = '0;
      chk(issue_valid == 1'b0, "R8 release latency", issue_valid, 0);
      @(negedge clk); expect_issue(2, 4);
      simd_done = 4'b0011;
      @(negedge clk); simd_done = '0;
      @(negedge clk); expect_issue(0, 5);
      chk(issue_thr_cnt == 7'd64, "R3 full wave", issue_thr_cnt, 64);
      chk(issue_tid_base == 10'd320, "R4 tid base", issue_tid_base, 320);
      simd_done = 4'b1111;
      @(negedge clk); simd_done = '0;
      chk(block_done == 1'b0, "R9 not yet done", block_done, 0);
      @(negedge clk);
      chk(block_done == 1'b1, "R9 done pulse", block_done, 1);
      chk(issue_valid == 1'b0, "R10 offer never accepted", issue_valid, 0);
      @(negedge clk);
      chk(block_done == 1'b0, "R9 pulse width", block_done, 0);
      chk(blk_ready == 1'b1, "R10 ready after done", blk_ready, 1);

      // table walk: R2 R3 R4 R5 R9 R11, units released right after each issue
      for (int t = 0; t < 8; t++) begin
         int  waves;
         int  last;
         bit  seen_done;
         blk_valid = 1'b1; blk_dim = 10'(TBL[t][0]); blk_idx = 8'(t + 20);
         @(negedge clk); blk_valid = 1'b0;
         waves = 0; last = 0; seen_done = 1'b0;
         for (int c = 0; c < 200 && !seen_done; c++) begin
            simd_done = '0;
            if (issue_valid) begin
               int exp_cnt;
               exp_cnt = (waves < TBL[t][1] - 1) ? 64 : TBL[t][2];
               chk(issue_wave_id == 5'(waves), "R2 wave order", issue_wave_id, waves);
               chk(issue_thr_cnt == 7'(exp_cnt), "R3 thread count", issue_thr_cnt, exp_cnt);
               chk(issue_tid_base == 10'(waves * 64), "R4 tid base", issue_tid_base, waves * 64);
               chk(issue_passes == 3'((exp_cnt + 15) / 16), "R5 passes", issue_passes, (exp_cnt + 15) / 16);
               chk(issue_blk_idx == 8'(t + 20), "R11 idx echo", issue_blk_idx, t + 20);
               last = int'(issue_thr_cnt);
               waves++;
               simd_done = issue_simd;
            end
            if (block_done) seen_done = 1'b1;
            @(negedge clk);
         end
         simd_done = '0;
         chk(waves == TBL[t][1], "R2 wave count", waves, TBL[t][1]);
         if (TBL[t][1] > 0) chk(last == TBL[t][2], "R3 last count", last, TBL[t][2]);
         chk(seen_done, "R9 block done seen", seen_done, 1);
         chk(block_done == 1'b0, "R9 single cycle", block_done, 0);
      end

      finish_run();
   end
endmodule